// File: doc/BRIEF.md
# Prioritized Event Vector Address Generator

This block arbitrates between a CPU's exception request lines and one autovectored external interrupt request, and decides whether the winner may interrupt the handler that is already running. Every exception line has a fixed priority class. The interrupt carries its own level, which the block maps to a class below all exceptions. An event is taken only when it outranks the class of the active handler and the pipeline reports an interruptible point. The class of the interrupted handler is pushed on a small stack so that a return-from-event can restore it.

When an event is taken, the block emits a one-cycle strobe, the source identifier and the handler target address. The address is formed by a bitwise OR of the event base register with the event's offset, never by addition. The base register's two low bits are ignored, so the base stays word aligned. Exception offsets use a wide spacing for the critical sources, so that a whole routine fits at the vector, and a four-byte spacing for the ordinary sources. The interrupt supplies a 14-bit autovector offset of its own. Context saving and resuming execution are handled elsewhere.

Top module: `evt_vector_unit`

## Requirements
- R1: With the defaults (3 exception lines, 8 classes), exception line i has class 7-i, so the lowest-indexed pending line wins, and any pending exception beats the interrupt. take_id reports the line index 0..2, or 3 for the interrupt.
- R2: The interrupt has class irq_level+1 (1..4). Class 0 means that no handler is active. A winner is taken only if its class is strictly greater than active_class. A pending event of equal or lower class waits without a strobe.
- R3: take is registered. It is high for exactly one cycle after the clock edge that sampled the winning request, and active_class takes the winner's class at that same edge. A request that is still held is not taken again.
- R4: No event is taken at an edge where safe_point is low. The request stays pending and is taken at the first edge where safe_point is high.
- R5: take_addr equals {evt_base[31:2],2'b00} OR the event offset, a bitwise OR and not a sum. For example, base 0x100 with offset 0x100 gives 0x100.
- R6: With the defaults, the exception offsets are 0x000 for line 0 (critical, 256-byte spacing), 0x100 for line 1 and 0x104 for line 2 (ordinary, 4-byte spacing).
- R7: For the interrupt, the offset is irq_offset (14 bits) zero-extended, which reaches up to 0x3FFF.
- R8: A high evt_return restores the class that was active before the most recent take. A return while active_class is 0 is ignored. No event is taken at an edge where evt_return is high.
- R9: After reset, take is 0, take_addr is 0, take_id is 0 and active_class is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | NUM_SRC | Exception request lines, index 0 highest priority |
| irq_req | input | 1 | External interrupt request |
| irq_level | input | clog2(IRQ_LEVELS) | Interrupt priority level |
| irq_offset | input | AV_W | Autovector offset for the interrupt |
| evt_base | input | ADDR_W | Event base register value |
| safe_point | input | 1 | Pipeline is at an interruptible point |
| evt_return | input | 1 | Return from the current handler |
| take | output | 1 | One-cycle take strobe |
| take_addr | output | ADDR_W | Handler target address |
| take_id | output | clog2(NUM_SRC+1) | Source taken (NUM_SRC = interrupt) |
| active_class | output | clog2(LEVELS) | Class of the running handler, 0 when idle |

## Verification
The assertions assume that the request inputs and evt_base hold a defined value at each edge. They also assume that no more returns are issued than events were taken, since a return at depth zero is simply dropped. The bench changes inputs one nanosecond after each rising edge and always lowers evt_return once active_class is back at 0. It sweeps every combination of exception lines, interrupt request and interrupt level against each reachable active class, with the base register's two low bits set, so that the masking and the OR rule are exercised on every vector.

// File: rtl/evt_vec_pkg.sv
package evt_vec_pkg;

   // Offset of exception source idx: critical sources first, wide spacing,
   // ordinary sources after them at the narrow spacing.
   function automatic int unsigned src_offset(int unsigned idx,
                                              int unsigned crit_num,
                                              int unsigned crit_gap,
                                              int unsigned ord_gap);
      if (idx < crit_num)
         return idx * crit_gap;
      return crit_num * crit_gap + (idx - crit_num) * ord_gap;
   endfunction

   typedef enum logic [1:0] {
      STK_HOLD = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2
   } stk_op_e;

endpackage

// File: rtl/evt_arbiter.sv
module evt_arbiter #(
   parameter int NUM_SRC    = 3,
   parameter int LEVELS     = 8,
   parameter int IRQ_LEVELS = 4,
   localparam int CLASS_W   = $clog2(LEVELS),
   localparam int LVL_W     = $clog2(IRQ_LEVELS),
   localparam int ID_W      = $clog2(NUM_SRC + 1)
) (
   input  logic [NUM_SRC-1:0] exc_req,
   input  logic               irq_req,
   input  logic [LVL_W-1:0]   irq_level,
   output logic               win_valid,
   output logic [CLASS_W-1:0] win_cls,
   output logic [ID_W-1:0]    win_id
);
   // Fixed class of each exception line, highest for line 0.
   logic [CLASS_W-1:0] src_cls [NUM_SRC];

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_cls
      assign src_cls[g] = CLASS_W'(LEVELS - 1 - g);
   end

   always_comb begin
      win_valid = 1'b0;
      win_cls   = '0;
      win_id    = '0;
      if (irq_req) begin
         win_valid = 1'b1;
         win_cls   = CLASS_W'(irq_level) + CLASS_W'(1);
         win_id    = ID_W'(NUM_SRC);
      end
      // Walk from the lowest priority line upward so line 0 has the last word.
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (exc_req[i]) begin
            win_valid = 1'b1;
            win_cls   = src_cls[i];
            win_id    = ID_W'(i);
         end
      end
   end

endmodule

// File: rtl/evt_addr_gen.sv
module evt_addr_gen
   import evt_vec_pkg::*;
#(
   parameter int NUM_SRC   = 3,
   parameter int ADDR_W    = 32,
   parameter int AV_W      = 14,
   parameter int CRIT_NUM  = 1,
   parameter int CRIT_GAP  = 256,
   parameter int ORD_GAP   = 4,
   localparam int ID_W     = $clog2(NUM_SRC + 1)
) (
   input  logic [ID_W-1:0]   sel_id,
   input  logic [AV_W-1:0]   irq_offset,
   input  logic [ADDR_W-1:0] evt_base,
   output logic [ADDR_W-1:0] target
);
   logic [ADDR_W-1:0] off_tab [NUM_SRC];
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] base_aligned;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_off
      assign off_tab[g] = ADDR_W'(src_offset(g, CRIT_NUM, CRIT_GAP, ORD_GAP));
   end

   // Variant choice: a base narrower than the autovector field is rejected
   // at elaboration in the top; here only the extension width differs.
   if (AV_W < ADDR_W) begin : g_av_ext
      always_comb begin
         offset = {{(ADDR_W-AV_W){1'b0}}, irq_offset};
         for (int i = 0; i < NUM_SRC; i++)
            if (sel_id == ID_W'(i)) offset = off_tab[i];
      end
   end else begin : g_av_full
      always_comb begin
         offset = ADDR_W'(irq_offset);
         for (int i = 0; i < NUM_SRC; i++)
            if (sel_id == ID_W'(i)) offset = off_tab[i];
      end
   end

   assign base_aligned = {evt_base[ADDR_W-1:2], 2'b00};
   assign target       = base_aligned | offset;

endmodule

// File: rtl/evt_class_stack.sv
module evt_class_stack
   import evt_vec_pkg::*;
#(
   parameter int LEVELS   = 8,
   localparam int CLASS_W = $clog2(LEVELS),
   localparam int DEPTH   = LEVELS - 1,
   localparam int PTR_W   = $clog2(DEPTH + 1),
   localparam int IDX_W   = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  stk_op_e            op,
   input  logic [CLASS_W-1:0] new_cls,
   output logic [CLASS_W-1:0] cur_cls,
   output logic               empty
);
   logic [CLASS_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]   ptr;

   assign empty = (ptr == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr     <= '0;
         cur_cls <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         unique case (op)
            STK_PUSH: begin
               mem[IDX_W'(ptr)] <= cur_cls;
               ptr              <= ptr + PTR_W'(1);
               cur_cls          <= new_cls;
            end
            STK_POP: begin
               cur_cls <= mem[IDX_W'(ptr - PTR_W'(1))];
               ptr     <= ptr - PTR_W'(1);
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/evt_vector_unit.sv
module evt_vector_unit
   import evt_vec_pkg::*;
#(
   parameter int NUM_SRC    = 3,
   parameter int LEVELS     = 8,
   parameter int IRQ_LEVELS = 4,
   parameter int ADDR_W     = 32,
   parameter int AV_W       = 14,
   parameter int CRIT_NUM   = 1,
   parameter int CRIT_GAP   = 256,
   parameter int ORD_GAP    = 4,
   localparam int CLASS_W   = $clog2(LEVELS),
   localparam int LVL_W     = $clog2(IRQ_LEVELS),
   localparam int ID_W      = $clog2(NUM_SRC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] exc_req,
   input  logic               irq_req,
   input  logic [LVL_W-1:0]   irq_level,
   input  logic [AV_W-1:0]    irq_offset,
   input  logic [ADDR_W-1:0]  evt_base,
   input  logic               safe_point,
   input  logic               evt_return,
   output logic               take,
   output logic [ADDR_W-1:0]  take_addr,
   output logic [ID_W-1:0]    take_id,
   output logic [CLASS_W-1:0] active_class
);
   // Elaboration-time configuration checks
   if (NUM_SRC + IRQ_LEVELS + 1 > LEVELS) begin : g_bad_classes
      $error("exception and interrupt classes do not fit in LEVELS");
   end
   if (LEVELS < 4 || (1 << CLASS_W) != LEVELS) begin : g_bad_levels
      $error("LEVELS must be a power of two of at least 4");
   end
   if (AV_W > ADDR_W || ADDR_W < 3) begin : g_bad_width
      $error("autovector field wider than the address");
   end
   if (ORD_GAP < 4 || CRIT_GAP < ORD_GAP) begin : g_bad_gap
      $error("handler spacing must be word sized and critical >= ordinary");
   end

   logic               win_valid;
   logic [CLASS_W-1:0] win_cls;
   logic [ID_W-1:0]    win_id;
   logic [ADDR_W-1:0]  target;
   logic               stk_empty;
   logic               go_take;
   logic               go_ret;
   stk_op_e            stk_op;

   evt_arbiter #(
      .NUM_SRC(NUM_SRC), .LEVELS(LEVELS), .IRQ_LEVELS(IRQ_LEVELS)
   ) arb_i (
      .exc_req(exc_req), .irq_req(irq_req), .irq_level(irq_level),
      .win_valid(win_valid), .win_cls(win_cls), .win_id(win_id)
   );

   evt_addr_gen #(
      .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .AV_W(AV_W),
      .CRIT_NUM(CRIT_NUM), .CRIT_GAP(CRIT_GAP), .ORD_GAP(ORD_GAP)
   ) agen_i (
      .sel_id(win_id), .irq_offset(irq_offset), .evt_base(evt_base),
      .target(target)
   );

   // Return wins over a take in the same cycle; depth zero returns drop.
   assign go_ret  = evt_return && !stk_empty;
   assign go_take = win_valid && safe_point && !evt_return &&
                    (win_cls > active_class);

   always_comb begin
      stk_op = STK_HOLD;
      if (go_ret)       stk_op = STK_POP;
      else if (go_take) stk_op = STK_PUSH;
   end

   evt_class_stack #(
      .LEVELS(LEVELS)
   ) stk_i (
      .clk(clk), .rst_n(rst_n), .op(stk_op), .new_cls(win_cls),
      .cur_cls(active_class), .empty(stk_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take      <= 1'b0;
         take_addr <= '0;
         take_id   <= '0;
      end else begin
         take <= go_take;
         if (go_take) begin
            take_addr <= target;
            take_id   <= win_id;
         end
      end
   end

endmodule

// File: rtl/evt_vector_chk.sv
module evt_vector_chk #(
   parameter int NUM_SRC    = 3,
   parameter int LEVELS     = 8,
   parameter int IRQ_LEVELS = 4,
   parameter int ADDR_W     = 32,
   parameter int AV_W       = 14,
   localparam int CLASS_W   = $clog2(LEVELS),
   localparam int LVL_W     = $clog2(IRQ_LEVELS),
   localparam int ID_W      = $clog2(NUM_SRC + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] exc_req,
   input logic               irq_req,
   input logic [LVL_W-1:0]   irq_level,
   input logic [AV_W-1:0]    irq_offset,
   input logic [ADDR_W-1:0]  evt_base,
   input logic               safe_point,
   input logic               evt_return,
   input logic               take,
   input logic [ADDR_W-1:0]  take_addr,
   input logic [ID_W-1:0]    take_id,
   input logic [CLASS_W-1:0] active_class
);
   logic [ADDR_W-1:0] base_m;
   assign base_m = {evt_base[ADDR_W-1:2], 2'b00};

   p_exc_beats_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (take && ($past(exc_req) != '0)) |-> (take_id < ID_W'(NUM_SRC)));

   p_class_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (active_class > $past(active_class)));

   p_class_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !$past(evt_return)) |-> $stable(active_class));

   p_safe_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(safe_point));

   p_base_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ((take_addr & $past(base_m)) == $past(base_m)));

   p_exc_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (take_id < ID_W'(NUM_SRC))) |-> (take_addr[1:0] == 2'b00));

   p_autovec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (take_id == ID_W'(NUM_SRC))) |->
      (take_addr[AV_W-1:0] == ($past(irq_offset) | $past(base_m[AV_W-1:0]))));

   p_no_take_on_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !$past(evt_return));

   p_ret_lowers_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(evt_return) && ($past(active_class) != '0)) |->
      (active_class < $past(active_class)));

endmodule

bind evt_vector_unit evt_vector_chk #(
   .NUM_SRC(NUM_SRC), .LEVELS(LEVELS), .IRQ_LEVELS(IRQ_LEVELS),
   .ADDR_W(ADDR_W), .AV_W(AV_W)
) chk_i (.*);

// File: tb/evt_vector_unit_tb_top.sv
`timescale 1ns/1ps
module evt_vector_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  exc_req = '0;
   logic        irq_req = 1'b0;
   logic [1:0]  irq_level = '0;
   logic [13:0] irq_offset = '0;
   logic [31:0] evt_base = '0;
   logic        safe_point = 1'b1;
   logic        evt_return = 1'b0;
   logic        take;
   logic [31:0] take_addr;
   logic [1:0]  take_id;
   logic [2:0]  active_class;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   evt_vector_unit dut_i (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .irq_req(irq_req),
      .irq_level(irq_level), .irq_offset(irq_offset), .evt_base(evt_base),
      .safe_point(safe_point), .evt_return(evt_return), .take(take),
      .take_addr(take_addr), .take_id(take_id), .active_class(active_class)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // Expected offset of exception line i (R6): critical 256-byte, then 4-byte.
   function automatic logic [31:0] exp_off(int i);
      return (i == 0) ? 32'h0 : 32'd256 + 32'(i - 1) * 32'd4;
   endfunction

   // Take a lone interrupt of a given level to set the active class.
   task automatic enter_irq(logic [1:0] lvl);
      irq_req = 1'b1; irq_level = lvl; irq_offset = 14'h0040;
      tick();
      irq_req = 1'b0;
   endtask

   task automatic do_return();
      evt_return = 1'b1;
      tick();
      evt_return = 1'b0;
   endtask

   // One sweep vector against a given active class.
   task automatic sweep_vec(logic [2:0] ac, logic [2:0] rq, bit ir,
                            logic [1:0] lv, int n);
      bit          ev;
      logic [2:0]  ecls;
      logic [1:0]  eid;
      logic [31:0] eoff, base;
      ev = 1'b0; ecls = '0; eid = '0; eoff = '0;
      base = {8'(n), 8'h5A, 16'h0003};
      if (ir) begin
         ev = 1'b1; ecls = 3'(lv) + 3'd1; eid = 2'd3;
         eoff = {18'h0, 12'hC00 | 12'(n), 2'b00};
      end
      for (int i = 2; i >= 0; i--)
         if (rq[i]) begin
            ev = 1'b1; ecls = 3'(7 - i); eid = 2'(i); eoff = exp_off(i);
         end
      exc_req = rq; irq_req = ir; irq_level = lv;
      irq_offset = eoff[13:0]; evt_base = base;
      tick();
      exc_req = '0; irq_req = 1'b0;
      if (ev && ecls > ac) begin
         chk("R1/R2 take", {31'h0, take}, 32'h1);
         chk("R1 id", {30'h0, take_id}, {30'h0, eid});
         chk("R5/R6/R7 addr", take_addr, (base & ~32'h3) | eoff);
         chk("R3 class", {29'h0, active_class}, {29'h0, ecls});
         do_return();
         chk("R8 restore", {29'h0, active_class}, {29'h0, ac});
      end else begin
         chk("R2 wait", {31'h0, take}, 32'h0);
         chk("R2 class held", {29'h0, active_class}, {29'h0, ac});
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) tick();
      // R9 reset state
      chk("R9 take", {31'h0, take}, 32'h0);
      chk("R9 addr", take_addr, 32'h0);
      chk("R9 id", {30'h0, take_id}, 32'h0);
      chk("R9 class", {29'h0, active_class}, 32'h0);
      rst_n = 1'b1;
      tick();

      // Sweep from idle
      for (int v = 0; v < 64; v++)
         sweep_vec(3'd0, 3'(v >> 3), v[2], 2'(v), v);
      // Sweep against each interrupt class
      for (int a = 0; a < 4; a++) begin
         enter_irq(2'(a));
         chk("R2 enter", {29'h0, active_class}, 32'(a + 1));
         for (int v = 0; v < 64; v++)
            sweep_vec(3'(a + 1), 3'(v >> 3), v[2], 2'(v), v + 64);
         do_return();
         chk("R8 back to idle", {29'h0, active_class}, 32'h0);
      end

      // R4: safe_point low blocks, then take on first safe edge
      evt_base = 32'h1000_0000;
      exc_req = 3'b100; safe_point = 1'b0;
      tick();
      chk("R4 blocked", {31'h0, take}, 32'h0);
      chk("R4 class", {29'h0, active_class}, 32'h0);
      safe_point = 1'b1;
      tick();
      chk("R4 taken", {31'h0, take}, 32'h1);
      chk("R4 addr", take_addr, 32'h1000_0104);
      tick();
      chk("R3 pulse ends", {31'h0, take}, 32'h0);
      chk("R3 class", {29'h0, active_class}, 32'h5);
      exc_req = '0;
      do_return();

      // R8: return at depth zero ignored, stack still usable
      do_return();
      chk("R8 empty return", {29'h0, active_class}, 32'h0);
      enter_irq(2'd0);
      chk("R8 after empty", {29'h0, active_class}, 32'h1);
      do_return();
      chk("R8 restore", {29'h0, active_class}, 32'h0);

      // R8: return and request in the same cycle, no take
      exc_req = 3'b001; evt_return = 1'b1;
      tick();
      chk("R8 no take on return", {31'h0, take}, 32'h0);
      evt_return = 1'b0;
      tick();
      chk("R8 take after", {31'h0, take}, 32'h1);
      exc_req = '0;
      do_return();

      // R5: OR, not add
      evt_base = 32'h0000_0103; exc_req = 3'b010;
      tick();
      exc_req = '0;
      chk("R5 or not sum", take_addr, 32'h0000_0100);
      do_return();

      // R7: widest autovector offset
      evt_base = 32'hFFFF_0000; irq_req = 1'b1; irq_level = 2'd3;
      irq_offset = 14'h3FFC;
      tick();
      irq_req = 1'b0;
      chk("R7 max offset", take_addr, 32'hFFFF_3FFC);
      do_return();

      // R2: nesting, equal and lower classes wait
      enter_irq(2'd0);
      enter_irq(2'd2);
      chk("R2 preempt", {29'h0, active_class}, 32'h3);
      irq_req = 1'b1; irq_level = 2'd1;
      tick();
      chk("R2 lower waits", {31'h0, take}, 32'h0);
      irq_level = 2'd2;
      tick();
      chk("R2 equal waits", {31'h0, take}, 32'h0);
      exc_req = 3'b100;
      tick();
      exc_req = '0; irq_req = 1'b0;
      chk("R1 exception preempts", {29'h0, active_class}, 32'h5);
      do_return();
      chk("R8 pop 1", {29'h0, active_class}, 32'h3);
      do_return();
      chk("R8 pop 2", {29'h0, active_class}, 32'h1);
      do_return();
      chk("R8 pop 3", {29'h0, active_class}, 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule